// File: doc/BRIEF.md
# Prioritized Bus Arbiter with Atomic-Sequence Locking

This block decides which of four bus masters owns a single shared external bus. The masters are, by index, a memory refresh engine (0), an external device asking for the bus (1), a DMA engine (2) and the processor (3). Each master presents three signals: a request, a cycle-in-progress flag and a one-cycle done pulse. It also presents a lock flag that it holds high for the whole of any sequence that must not be split. Such sequences include cache-line fill bursts, 16-byte block moves, read-modify-write test-and-set pairs, and the sub-cycles of an access wider than the memory port.

Ownership changes only at a bus-cycle boundary. A boundary is either the owner's done pulse or the owner having no cycle in progress, and in both cases the owner's lock must be low. A handover always runs in three steps. First, the outgoing owner keeps the bus for one cycle with every control signal forced to its inactive level. Next comes one idle cycle with no grant. Then the new owner takes the bus. A per-cycle lock means that interrupt-entry accesses (vector fetch, PC save, status save) remain separately arbitrable, because the processor leaves lock low between them. With the partial-share input high, the block keeps the output drivers enabled at all times, including the idle cycle.

Top module: `bus_arbiter`

## Requirements
- R1: When several masters request together, the winner is the lowest index: refresh (0), then external (1), then DMA (2), then processor (3). Grant bit i of `gnt_o` belongs to master i.
- R2: Ownership moves only at a boundary. A boundary is `done_i[owner]` high, or `cyc_i[owner]` low. While the owner has a cycle in progress and no done pulse, the grant holds.
- R3: While `lock_i[owner]` is high, no handover starts, even on done pulses and even with a higher-priority request pending.
- R4: A done pulse that arrives with lock low ends the owner's tenure if a different master wins. This lets independent back-to-back accesses, such as interrupt-entry cycles, be split.
- R5: A handover begins with one cycle in which the outgoing grant is still asserted, `ctl_neg_o` is 1 (control signals negated) and `drv_en_o` is 1.
- R6: After that cycle comes exactly one idle cycle with `gnt_o` = 0 and `ctl_neg_o` = 1. In this cycle `drv_en_o` is 0 unless partial-share is selected. The new owner then appears with `ctl_neg_o` = 0.
- R7: `gnt_o` is always one-hot or all-zero.
- R8: When no master requests, the processor (index 3) is granted by default.
- R9: During reset, `gnt_o` = 0, `ctl_neg_o` = 1 and `drv_en_o` = `partial_i`. The first rising edge with reset released grants the winner.
- R10: With `partial_i` = 1, `drv_en_o` stays 1 in every state.
- R11: If the owner is still the winner at a boundary, it keeps the bus with no negation cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| partial_i | input | 1 | Partial-share mode: keep drivers enabled always |
| req_i | input | N_REQ | Bus request per master |
| cyc_i | input | N_REQ | Bus cycle in progress per master |
| done_i | input | N_REQ | One-cycle pulse at the end of a bus cycle |
| lock_i | input | N_REQ | High across an atomic multi-cycle sequence |
| gnt_o | output | N_REQ | One-hot bus grant |
| ctl_neg_o | output | 1 | 1 forces all bus control signals to the negated level |
| drv_en_o | output | 1 | Output driver enable for the bus pins |

## Verification
The patterns below each separate one piece of behaviour from the others:
- All four requests arriving together show the fixed order.
- A lower-priority request that waits while the owner's cycle lacks a done pulse shows that requests alone do not move the bus.
- A locked burst with several done pulses and a pending refresh separates the lock from the done handshake. The processor handing over after a single unlocked done pulse confirms that interrupt-entry style accesses stay splittable.
- Dropping every request exposes the default owner.
- An owner that stays the winner at a boundary shows that no needless negation cycle is inserted.
- Repeating a handover in partial-share mode separates the driver enable from the grant sequence.

// File: rtl/arb_pkg.sv
// Package: shared types for the bus arbiter.
// Assumes: three-state handover sequence; master index 0 has highest priority.
package arb_pkg;
    typedef enum logic [1:0] {
        ST_GAP = 2'd0,   // no owner, control negated
        ST_OWN = 2'd1,   // owner drives the bus
        ST_NEG = 2'd2    // owner still granted, control negated
    } arb_state_t;
endpackage

// File: rtl/arb_prio.sv
// Fixed-priority selector: lowest set request index wins.
// Assumes: DEF_IDX is returned when no request is set.
module arb_prio #(
    parameter int N_REQ   = 4,
    parameter int DEF_IDX = N_REQ - 1,
    localparam int IW     = $clog2(N_REQ)
) (
    input  logic [N_REQ-1:0] req_i,
    output logic [IW-1:0]    win_o
);
    logic [N_REQ-1:0] seen;
    logic [N_REQ-1:0] pick;

    // prefix OR chain marking requests at or above each priority level
    assign seen[0] = req_i[0];
    assign pick[0] = req_i[0];
    for (genvar g = 1; g < N_REQ; g++) begin : g_chain
        assign seen[g] = seen[g-1] | req_i[g];
        assign pick[g] = req_i[g] & ~seen[g-1];
    end

    // encode the single picked bit, falling back to the default owner
    always_comb begin
        win_o = IW'(DEF_IDX);
        for (int i = 0; i < N_REQ; i++) begin
            if (pick[i]) win_o = IW'(i);
        end
    end
endmodule

// File: rtl/arb_bound.sv
// Boundary detector: tells when the current owner may be replaced.
// Assumes: done_i is a one-cycle pulse; lock_i covers a whole atomic sequence.
module arb_bound #(
    parameter int N_REQ = 4,
    localparam int IW   = $clog2(N_REQ)
) (
    input  logic [IW-1:0]    owner_i,
    input  logic [N_REQ-1:0] cyc_i,
    input  logic [N_REQ-1:0] done_i,
    input  logic [N_REQ-1:0] lock_i,
    output logic             bnd_o
);
    // a cycle end or no cycle at all, never inside a locked sequence
    always_comb begin
        bnd_o = (done_i[owner_i] | ~cyc_i[owner_i]) & ~lock_i[owner_i];
    end
endmodule

// File: rtl/arb_fsm.sv
// Handover sequencer: OWN -> NEG -> GAP -> OWN(new owner).
// Assumes: win_i is valid every cycle; owner loads only in GAP.
module arb_fsm
    import arb_pkg::*;
#(
    parameter int N_REQ   = 4,
    parameter int DEF_IDX = N_REQ - 1,
    localparam int IW     = $clog2(N_REQ)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] win_i,
    input  logic          bnd_i,
    output arb_state_t    state_o,
    output logic [IW-1:0] owner_o
);
    arb_state_t    state_q;
    logic [IW-1:0] owner_q;

    // state and owner register with synchronous reset to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_GAP;
            owner_q <= IW'(DEF_IDX);
        end else begin
            unique case (state_q)
                ST_GAP: begin
                    owner_q <= win_i;
                    state_q <= ST_OWN;
                end
                ST_OWN: begin
                    if (bnd_i && (win_i != owner_q)) state_q <= ST_NEG;
                end
                ST_NEG:  state_q <= ST_GAP;
                default: state_q <= ST_GAP;
            endcase
        end
    end

    assign state_o = state_q;
    assign owner_o = owner_q;
endmodule

// File: rtl/arb_drive.sv
// Output decode: grant vector, control negation and driver enable.
// Assumes: partial_i selects always-driven pins.
module arb_drive
    import arb_pkg::*;
#(
    parameter int N_REQ = 4,
    localparam int IW   = $clog2(N_REQ)
) (
    input  arb_state_t       state_i,
    input  logic [IW-1:0]    owner_i,
    input  logic             partial_i,
    output logic [N_REQ-1:0] gnt_o,
    output logic             ctl_neg_o,
    output logic             drv_en_o
);
    // grant held in OWN and NEG, dropped in GAP
    always_comb begin
        gnt_o = '0;
        if (state_i != ST_GAP) gnt_o[owner_i] = 1'b1;
    end

    // control active only while owning; drivers off only in the gap
    always_comb begin
        ctl_neg_o = (state_i != ST_OWN);
        drv_en_o  = (state_i != ST_GAP) | partial_i;
    end
endmodule

// File: rtl/bus_arbiter.sv
// Top: four-master fixed-priority bus arbiter with atomic locking and
// a negate/idle handover sequence.
// Assumes: index 0 highest priority, index N_REQ-1 default owner.
module bus_arbiter
    import arb_pkg::*;
#(
    parameter int N_REQ = 4,
    localparam int IW   = $clog2(N_REQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             partial_i,
    input  logic [N_REQ-1:0] req_i,
    input  logic [N_REQ-1:0] cyc_i,
    input  logic [N_REQ-1:0] done_i,
    input  logic [N_REQ-1:0] lock_i,
    output logic [N_REQ-1:0] gnt_o,
    output logic             ctl_neg_o,
    output logic             drv_en_o
);
    logic [IW-1:0] win;
    logic [IW-1:0] owner;
    logic          bnd;
    arb_state_t    state;

    arb_prio #(.N_REQ(N_REQ)) u_prio (
        .req_i (req_i),
        .win_o (win)
    );

    arb_bound #(.N_REQ(N_REQ)) u_bound (
        .owner_i (owner),
        .cyc_i   (cyc_i),
        .done_i  (done_i),
        .lock_i  (lock_i),
        .bnd_o   (bnd)
    );

    arb_fsm #(.N_REQ(N_REQ)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_i   (win),
        .bnd_i   (bnd),
        .state_o (state),
        .owner_o (owner)
    );

    arb_drive #(.N_REQ(N_REQ)) u_drive (
        .state_i   (state),
        .owner_i   (owner),
        .partial_i (partial_i),
        .gnt_o     (gnt_o),
        .ctl_neg_o (ctl_neg_o),
        .drv_en_o  (drv_en_o)
    );
endmodule

// File: rtl/bus_arbiter_chk.sv
// Checker: port-level properties of the bus arbiter, bound to the top.
module bus_arbiter_chk #(
    parameter int N_REQ = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             partial_i,
    input logic [N_REQ-1:0] cyc_i,
    input logic [N_REQ-1:0] done_i,
    input logic [N_REQ-1:0] lock_i,
    input logic [N_REQ-1:0] gnt_o,
    input logic             ctl_neg_o,
    input logic             drv_en_o
);
    logic owner_free;
    assign owner_free = |(gnt_o & (done_i | ~cyc_i) & ~lock_i);

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));                                              // R7

    AST_HOLD_NO_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && !ctl_neg_o && !owner_free)
        |=> ($stable(gnt_o) && !ctl_neg_o));                           // R2

    AST_NEG_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|gnt_o) |-> $past(ctl_neg_o));                           // R5

    AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o != '0 && $past(gnt_o) != '0) |-> gnt_o == $past(gnt_o)); // R6

    AST_IDLE_NEGATED: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o == '0) |-> (ctl_neg_o && (drv_en_o == partial_i)));     // R6

    AST_PARTIAL_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        partial_i |-> drv_en_o);                                       // R10
endmodule

bind bus_arbiter bus_arbiter_chk #(.N_REQ(N_REQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .partial_i (partial_i),
    .cyc_i     (cyc_i),
    .done_i    (done_i),
    .lock_i    (lock_i),
    .gnt_o     (gnt_o),
    .ctl_neg_o (ctl_neg_o),
    .drv_en_o  (drv_en_o)
);

// File: tb/bus_arbiter_bench.sv
`timescale 1ns/1ps
module bus_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       partial = 1'b0;
    logic [3:0] req = '0, cyc = '0, done = '0, lock = '0;
    logic [3:0] gnt;
    logic       ctl_neg, drv_en;
    int         n_chk = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #2.5 clk = ~clk;

    bus_arbiter #(.N_REQ(4)) u_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .partial_i(partial),
        .req_i(req), .cyc_i(cyc), .done_i(done), .lock_i(lock),
        .gnt_o(gnt), .ctl_neg_o(ctl_neg), .drv_en_o(drv_en)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic [3:0] eg, input logic en,
                              input logic ed, input string tag);
        n_chk++;
        if (gnt !== eg || ctl_neg !== en || drv_en !== ed) begin
            n_fail++;
            $display("FAIL %s: gnt=%b neg=%b drv=%b expected gnt=%b neg=%b drv=%b",
                     tag, gnt, ctl_neg, drv_en, eg, en, ed);
        end
    endtask

    task automatic t_reset;
        tick(2);
        expect_out(4'b0000, 1'b1, 1'b0, "R9 in reset");
        rst_n = 1'b1;
        #1 expect_out(4'b0000, 1'b1, 1'b0, "R9 idle after release");
        tick(1);
        expect_out(4'b1000, 1'b0, 1'b1, "R8 default owner after reset");
    endtask

    task automatic t_priority;
        req = 4'b1111;
        tick(1); expect_out(4'b1000, 1'b1, 1'b1, "R5 negate cycle");
        tick(1); expect_out(4'b0000, 1'b1, 1'b0, "R6 idle gap");
        tick(1); expect_out(4'b0001, 1'b0, 1'b1, "R1 refresh wins");
    endtask

    task automatic t_boundary;
        cyc = 4'b0001; req = 4'b0010;
        for (int i = 0; i < 3; i++) begin
            tick(1); expect_out(4'b0001, 1'b0, 1'b1, "R2 hold mid-cycle");
        end
        done = 4'b0001;
        tick(1); expect_out(4'b0001, 1'b1, 1'b1, "R2 handover at done");
        done = '0; cyc = '0;
        tick(1); expect_out(4'b0000, 1'b1, 1'b0, "R6 gap");
        tick(1); expect_out(4'b0010, 1'b0, 1'b1, "R1 external granted");
    endtask

    task automatic t_lock;
        cyc = 4'b0010; lock = 4'b0010; req = 4'b0011;
        for (int i = 0; i < 3; i++) begin
            done = 4'b0010;
            tick(1); expect_out(4'b0010, 1'b0, 1'b1, "R3 locked beat");
            done = '0;
            tick(1); expect_out(4'b0010, 1'b0, 1'b1, "R3 locked gap");
        end
        done = 4'b0010; lock = '0;
        tick(1); expect_out(4'b0010, 1'b1, 1'b1, "R3 release after last beat");
        done = '0; cyc = '0;
        tick(2); expect_out(4'b0001, 1'b0, 1'b1, "R1 refresh after lock");
    endtask

    task automatic t_default;
        req = '0;
        tick(1); expect_out(4'b0001, 1'b1, 1'b1, "R8 negate to default");
        tick(2); expect_out(4'b1000, 1'b0, 1'b1, "R8 processor default");
    endtask

    task automatic t_irq_entry;
        req = 4'b1000; cyc = 4'b1000;
        tick(1); expect_out(4'b1000, 1'b0, 1'b1, "R11 owner stays");
        req = 4'b1010;
        tick(1); expect_out(4'b1000, 1'b0, 1'b1, "R2 no done no move");
        done = 4'b1000;
        tick(1); expect_out(4'b1000, 1'b1, 1'b1, "R4 split after single access");
        done = '0; cyc = '0;
        tick(2); expect_out(4'b0010, 1'b0, 1'b1, "R4 external takes over");
    endtask

    task automatic t_stay;
        req = 4'b1010;
        tick(2); expect_out(4'b0010, 1'b0, 1'b1, "R11 winner keeps bus");
    endtask

    task automatic t_partial;
        partial = 1'b1; req = '0;
        tick(1); expect_out(4'b0010, 1'b1, 1'b1, "R10 negate cycle");
        tick(1); expect_out(4'b0000, 1'b1, 1'b1, "R10 gap still driven");
        tick(1); expect_out(4'b1000, 1'b0, 1'b1, "R10 new owner");
    endtask

    initial begin
        t_reset();
        t_priority();
        t_boundary();
        t_lock();
        t_default();
        t_irq_entry();
        t_stay();
        t_partial();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule